// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

This block holds one single-entry mailbox for each processor. A system-side sender offers interrupt messages, each naming a target CPU, a source ID and two 64-bit data words. A message is taken only when the target's mailbox is empty. A taken message is latched into that mailbox, the mailbox turns busy, and an interrupt is posted to the target CPU. All mailboxes share one programmable interrupt vector.

Software reaches the mailboxes through a register port that also carries the ID of the CPU making the request. Each data word and each status word can be read by CPU index. Three self-relative aliases resolve to the requester's own mailbox. A mailbox is released by writing 0 into the busy bit of its status word. There is no queueing: while a mailbox is busy, further messages for that CPU are refused. The sender may hold a refused message and offer it again later, or drop it.

The message input follows valid/ready rules. `msg_ready` is a combinational function of `msg_cpu` and of the register write in the same cycle. A transfer happens on a rising edge where `msg_valid` and `msg_ready` are both high. A cycle with `msg_valid` high and `msg_ready` low is a refusal, and it leaves no trace in the block. `msg_ready` does not depend on `msg_valid`.

Top module: `cpu_irq_mailbox`

## Requirements
- R1: After reset, every busy flag, source ID, data word and the vector register read as zero, and `post_valid` and `reg_rvalid` are low.
- R2: `msg_ready` is high in the same cycle exactly when `msg_cpu` is below NUM_CPUS, that CPU's busy flag is clear, and no status write aims at that CPU in this cycle.
- R3: A refused message (valid high, ready low) changes no busy flag, source ID or data word.
- R4: An accepted message sets the target's busy flag and stores the source ID and both data words. In the following cycle `post_valid` is high for one cycle, with `post_cpu` equal to the target and `post_vec` equal to the vector register value held before the accepting edge.
- R5: The vector register is at byte offset 0x318. A write keeps bits 5:0 of the write data. A read returns those bits with all higher bits zero.
- R6: The status word of CPU i is at byte offset 0x200+8*i. It reads with busy in bit 5 and the source ID in bits 4:0, and all other bits zero.
- R7: A write to a status word loads busy from bit 5 of the write data and leaves the source ID unchanged. Writing 0 frees the mailbox.
- R8: Data word 0 of CPU i reads at 0x000+8*i, and data word 1 reads at 0x100+8*i.
- R9: Offsets 0x300 (data word 0), 0x308 (data word 1) and 0x310 (status, read and write) act on the mailbox of the CPU given on `reg_cpu`.
- R10: When a message and a status write (indexed or alias) target the same CPU in one cycle, the message is refused and the write takes effect.
- R11: A read returns `reg_rdata` with `reg_rvalid` high one cycle after the request. Address bits 2:0 are ignored. An unmapped offset or an index of NUM_CPUS or more reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A message is offered |
| msg_ready | output | 1 | Target mailbox can take the message this cycle |
| msg_cpu | input | 2 | Target CPU of the message |
| msg_src | input | 5 | Source ID of the message |
| msg_d0 | input | 64 | First data word |
| msg_d1 | input | 64 | Second data word |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte offset of the register |
| reg_cpu | input | 2 | ID of the requesting CPU, used by the aliases |
| reg_wdata | input | 64 | Write data |
| reg_rvalid | output | 1 | Read data is valid |
| reg_rdata | output | 64 | Read data |
| post_valid | output | 1 | One-cycle interrupt post |
| post_cpu | output | 2 | CPU that receives the interrupt |
| post_vec | output | 6 | Interrupt vector posted |

## Verification
`msg_ready` is due in the same cycle as the offer, so the bench samples it 1 ns after driving the inputs, before the next edge. Every other result is due one edge later: `post_valid`, `post_cpu` and `post_vec` for an accepted message, `reg_rvalid` and `reg_rdata` for a read, and the new state for a write, which becomes visible to a read issued in the next cycle. The bench reference model takes its expectations from the state held before each edge, applies the updates at the edge, and compares 1 ns after the edge. Same-edge cases are therefore checked as the requirements define them: a read of a mailbox being filled returns the old value, and a vector written in the accepting cycle is not the vector posted.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W   = 10;
  localparam int IDX_LSB  = 3;
  localparam int IDX_W    = 5;
  localparam int BUSY_BIT = 5;

  // region codes in reg_addr[9:8]
  localparam logic [1:0] RGN_DATA0 = 2'd0;
  localparam logic [1:0] RGN_DATA1 = 2'd1;
  localparam logic [1:0] RGN_STAT  = 2'd2;
  localparam logic [1:0] RGN_MISC  = 2'd3;

  // slot codes in reg_addr[7:3] inside the misc region
  localparam logic [IDX_W-1:0] MISC_SELF_D0   = 5'd0;
  localparam logic [IDX_W-1:0] MISC_SELF_D1   = 5'd1;
  localparam logic [IDX_W-1:0] MISC_SELF_STAT = 5'd2;
  localparam logic [IDX_W-1:0] MISC_VECTOR    = 5'd3;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_D0,
    KIND_D1,
    KIND_STAT,
    KIND_VEC
  } reg_kind_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CPU_W-1:0]  self_i,
  output reg_kind_e         kind_o,
  output logic [CPU_W-1:0]  idx_o
);
  logic [1:0]       region;
  logic [IDX_W-1:0] field;
  logic             in_range;
  logic             unused_lsb;

  assign region     = addr_i[ADDR_W-1:ADDR_W-2];
  assign field      = addr_i[IDX_LSB+IDX_W-1:IDX_LSB];
  assign unused_lsb = ^addr_i[IDX_LSB-1:0];
  assign in_range   = (32'(field) < NUM_CPUS);

  always_comb begin
    kind_o = KIND_NONE;
    idx_o  = field[CPU_W-1:0];
    unique case (region)
      RGN_DATA0: if (in_range) kind_o = KIND_D0;
      RGN_DATA1: if (in_range) kind_o = KIND_D1;
      RGN_STAT:  if (in_range) kind_o = KIND_STAT;
      default: begin
        idx_o = self_i;
        case (field)
          MISC_SELF_D0:   kind_o = KIND_D0;
          MISC_SELF_D1:   kind_o = KIND_D1;
          MISC_SELF_STAT: kind_o = KIND_STAT;
          MISC_VECTOR:    kind_o = KIND_VEC;
          default:        kind_o = KIND_NONE;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W = 64,
  parameter int SRC_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [DATA_W-1:0] d0_i,
  input  logic [DATA_W-1:0] d1_i,
  input  logic              sw_we_i,
  input  logic              sw_busy_i,
  output logic              busy_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [DATA_W-1:0] d0_o,
  output logic [DATA_W-1:0] d1_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      src_o  <= '0;
      d0_o   <= '0;
      d1_o   <= '0;
    end else if (sw_we_i) begin
      busy_o <= sw_busy_i;
    end else if (acc_i) begin
      busy_o <= 1'b1;
      src_o  <= src_i;
      d0_o   <= d0_i;
      d1_o   <= d1_i;
    end
  end

  // the top must never offer a message to a slot being written by software
  assert_no_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_i && sw_we_i));

  // contents move only on an accept or a software write
  assert_refused_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_i && !sw_we_i) |=> ($stable(busy_o) && $stable(src_o) && $stable(d0_o) && $stable(d1_o)));

  assert_accept_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |=> (busy_o && src_o == $past(src_i) && d0_o == $past(d0_i) && d1_o == $past(d1_i)));

  assert_sw_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we_i |=> (busy_o == $past(sw_busy_i) && $stable(src_o)));
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
  import mbx_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int DATA_W   = 64,
  parameter int SRC_W    = 5,
  parameter int VEC_W    = 6,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  reg_kind_e         kind_i,
  input  logic [CPU_W-1:0]  idx_i,
  input  logic [NUM_CPUS-1:0] busy_i,
  input  logic [SRC_W-1:0]  src_i [NUM_CPUS],
  input  logic [DATA_W-1:0] d0_i  [NUM_CPUS],
  input  logic [DATA_W-1:0] d1_i  [NUM_CPUS],
  input  logic [VEC_W-1:0]  vec_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[BUSY_BIT]    = busy_i[idx_i];
    stat_word[SRC_W-1:0]   = src_i[idx_i];
  end

  always_comb begin
    data_o = '0;
    case (kind_i)
      KIND_D0:   data_o = d0_i[idx_i];
      KIND_D1:   data_o = d1_i[idx_i];
      KIND_STAT: data_o = stat_word;
      KIND_VEC:  data_o[VEC_W-1:0] = vec_i;
      default:   data_o = '0;
    endcase
  end
endmodule

// File: rtl/cpu_irq_mailbox.sv
module cpu_irq_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int DATA_W   = 64,
  parameter int SRC_W    = 5,
  parameter int VEC_W    = 6,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [CPU_W-1:0]  msg_cpu,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [DATA_W-1:0] msg_d0,
  input  logic [DATA_W-1:0] msg_d1,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CPU_W-1:0]  reg_cpu,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec
);
  reg_kind_e          kind;
  logic [CPU_W-1:0]   idx;
  logic               stat_we;
  logic               vec_we;
  logic               cpu_ok;
  logic               take;
  logic [VEC_W-1:0]   vec_q;
  logic [NUM_CPUS-1:0] busy_v;
  logic [SRC_W-1:0]   src_a [NUM_CPUS];
  logic [DATA_W-1:0]  d0_a  [NUM_CPUS];
  logic [DATA_W-1:0]  d1_a  [NUM_CPUS];
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata;

  mbx_decode #(.NUM_CPUS(NUM_CPUS)) u_dec (
    .addr_i (reg_addr),
    .self_i (reg_cpu),
    .kind_o (kind),
    .idx_o  (idx)
  );

  assign stat_we = reg_en && reg_we && (kind == KIND_STAT);
  assign vec_we  = reg_en && reg_we && (kind == KIND_VEC);
  assign cpu_ok  = (32'(msg_cpu) < NUM_CPUS);

  // software status write to the same CPU wins over an incoming message
  assign msg_ready = cpu_ok && !busy_v[msg_cpu] && !(stat_we && idx == msg_cpu);
  assign take      = msg_valid && msg_ready;

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_slot
    mbx_slot #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_i     (take && msg_cpu == CPU_W'(g)),
      .src_i     (msg_src),
      .d0_i      (msg_d0),
      .d1_i      (msg_d1),
      .sw_we_i   (stat_we && idx == CPU_W'(g)),
      .sw_busy_i (reg_wdata[BUSY_BIT]),
      .busy_o    (busy_v[g]),
      .src_o     (src_a[g]),
      .d0_o      (d0_a[g]),
      .d1_o      (d1_a[g])
    );
  end

  mbx_rdmux #(.NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W), .SRC_W(SRC_W), .VEC_W(VEC_W)) u_mux (
    .kind_i (kind),
    .idx_i  (idx),
    .busy_i (busy_v),
    .src_i  (src_a),
    .d0_i   (d0_a),
    .d1_i   (d1_a),
    .vec_i  (vec_q),
    .data_o (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (vec_we) vec_q <= reg_wdata[VEC_W-1:0];
      post_valid <= take;
      if (take) begin
        post_cpu <= msg_cpu;
        post_vec <= vec_q;
      end
      reg_rvalid <= reg_en && !reg_we;
      if (reg_en && !reg_we) reg_rdata <= rd_mux;
    end
  end

  assert_refuse_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && cpu_ok && busy_v[msg_cpu]) |-> !msg_ready);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && idx == msg_cpu) |-> !msg_ready);

  assert_post_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> (post_valid && post_cpu == $past(msg_cpu) && post_vec == $past(vec_q)));

  assert_post_only_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && msg_ready) |=> !post_valid);

  assert_vec_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |=> vec_q == $past(reg_wdata[VEC_W-1:0]));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we) |=> reg_rvalid);
endmodule

// File: tb/cpu_irq_mailbox_tb_top.sv
module cpu_irq_mailbox_tb_top;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [1:0]  msg_cpu = '0;
  logic [4:0]  msg_src = '0;
  logic [63:0] msg_d0 = '0;
  logic [63:0] msg_d1 = '0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [1:0]  reg_cpu = '0;
  logic [63:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [63:0] reg_rdata;
  logic        post_valid;
  logic [1:0]  post_cpu;
  logic [5:0]  post_vec;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          m_busy [NC];
  logic [4:0]  m_src  [NC];
  logic [63:0] m_d0   [NC];
  logic [63:0] m_d1   [NC];
  logic [5:0]  m_vec;

  always #10 clk = ~clk;

  cpu_irq_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_cpu(msg_cpu),
    .msg_src(msg_src), .msg_d0(msg_d0), .msg_d1(msg_d1),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_cpu(reg_cpu),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // map of the register space, per requirements R6, R8, R9, R5, R11
  // kind: 0 none, 1 data0, 2 data1, 3 status, 4 vector
  function automatic int kind_of(input logic [9:0] a);
    int f = int'(a[7:3]);
    case (a[9:8])
      2'd0: return (f < NC) ? 1 : 0;
      2'd1: return (f < NC) ? 2 : 0;
      2'd2: return (f < NC) ? 3 : 0;
      default: case (f)
        0: return 1;
        1: return 2;
        2: return 3;
        3: return 4;
        default: return 0;
      endcase
    endcase
  endfunction

  function automatic int target_of(input logic [9:0] a, input logic [1:0] self);
    if (a[9:8] == 2'd3) return int'(self);
    return int'(a[7:3]);
  endfunction

  function automatic logic [63:0] model_read(input logic [9:0] a, input logic [1:0] self);
    int k = kind_of(a);
    int t = target_of(a, self);
    logic [63:0] v = '0;
    case (k)
      1: v = m_d0[t];
      2: v = m_d1[t];
      3: begin v[5] = m_busy[t]; v[4:0] = m_src[t]; end
      4: v[5:0] = m_vec;
      default: v = '0;
    endcase
    return v;
  endfunction

  // one clock: compare combinational ready, step the model, compare registered results
  task automatic cycle(input string tag);
    bit          exp_rdy, exp_pv, exp_rv, sw_hit;
    logic [1:0]  exp_pc;
    logic [5:0]  exp_pvec;
    logic [63:0] exp_rd;
    int          wk, wt;
    #1;
    wk = kind_of(reg_addr);
    wt = target_of(reg_addr, reg_cpu);
    sw_hit  = reg_en && reg_we && wk == 3 && wt == int'(msg_cpu);
    exp_rdy = !m_busy[msg_cpu] && !sw_hit;
    chk({63'b0, msg_ready}, {63'b0, exp_rdy}, {"R2 R10 msg_ready ", tag});
    exp_pv   = msg_valid && exp_rdy;
    exp_pc   = msg_cpu;
    exp_pvec = m_vec;
    exp_rv   = reg_en && !reg_we;
    exp_rd   = model_read(reg_addr, reg_cpu);
    @(posedge clk);
    if (reg_en && reg_we) begin
      if (wk == 3) m_busy[wt] = reg_wdata[5];
      if (wk == 4) m_vec = reg_wdata[5:0];
    end
    if (exp_pv) begin
      m_busy[exp_pc] = 1'b1;
      m_src[exp_pc]  = msg_src;
      m_d0[exp_pc]   = msg_d0;
      m_d1[exp_pc]   = msg_d1;
    end
    #1;
    chk({63'b0, post_valid}, {63'b0, exp_pv}, {"R4 post_valid ", tag});
    if (exp_pv) begin
      chk({62'b0, post_cpu}, {62'b0, exp_pc}, {"R4 post_cpu ", tag});
      chk({58'b0, post_vec}, {58'b0, exp_pvec}, {"R4 post_vec ", tag});
    end
    chk({63'b0, reg_rvalid}, {63'b0, exp_rv}, {"R11 reg_rvalid ", tag});
    if (exp_rv) chk(reg_rdata, exp_rd, {"rdata ", tag});
    msg_valid = 1'b0;
    reg_en    = 1'b0;
    reg_we    = 1'b0;
  endtask

  task automatic put_msg(input logic [1:0] c, input logic [4:0] s, input logic [63:0] a, input logic [63:0] b);
    msg_valid = 1'b1; msg_cpu = c; msg_src = s; msg_d0 = a; msg_d1 = b;
  endtask

  task automatic put_rd(input logic [9:0] a, input logic [1:0] self);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a; reg_cpu = self;
  endtask

  task automatic put_wr(input logic [9:0] a, input logic [1:0] self, input logic [63:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_cpu = self; reg_wdata = d;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired, R11 run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      m_busy[i] = 0; m_src[i] = '0; m_d0[i] = '0; m_d1[i] = '0;
    end
    m_vec = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: outputs idle, whole map reads zero
    chk({63'b0, post_valid}, 64'd0, "R1 post_valid after reset");
    chk({63'b0, reg_rvalid}, 64'd0, "R1 reg_rvalid after reset");
    for (int i = 0; i < NC; i++) begin
      put_rd(10'h000 + 10'(8*i), 2'd0); cycle("R1 data0");
      put_rd(10'h100 + 10'(8*i), 2'd0); cycle("R1 data1");
      put_rd(10'h200 + 10'(8*i), 2'd0); cycle("R1 status");
    end
    put_rd(10'h318, 2'd0); cycle("R1 vector");

    // R5: vector keeps only bits 5:0
    put_wr(10'h318, 2'd0, 64'hFFFF_0000_0000_00E5); cycle("R5 write");
    put_rd(10'h318, 2'd0); cycle("R5 readback");
    chk(reg_rdata, 64'h25, "R5 vector value");

    // R4: accept, then post
    put_msg(2'd1, 5'd7, 64'hA1A1_0000_1111_2222, 64'hB1B1_3333_4444_5555); cycle("R4 accept cpu1");
    chk({63'b0, post_valid}, 64'd1, "R4 post pulse");
    chk({58'b0, post_vec}, 64'h25, "R4 vector posted");
    cycle("R4 idle");
    chk({63'b0, post_valid}, 64'd0, "R4 single pulse");

    // R3: refused while busy
    put_msg(2'd1, 5'd3, 64'hDEAD, 64'hBEEF); cycle("R3 refuse busy");
    put_rd(10'h008, 2'd0); cycle("R8 R3 data0 idx1");
    chk(reg_rdata, 64'hA1A1_0000_1111_2222, "R3 data0 unchanged");
    put_rd(10'h108, 2'd0); cycle("R8 R3 data1 idx1");
    put_rd(10'h208, 2'd0); cycle("R6 R3 status idx1");
    chk(reg_rdata, 64'h27, "R6 status busy+src");

    // R9: aliases from CPU 1 and from CPU 2
    put_rd(10'h300, 2'd1); cycle("R9 alias data0");
    put_rd(10'h308, 2'd1); cycle("R9 alias data1");
    put_rd(10'h310, 2'd1); cycle("R9 alias status");
    put_rd(10'h310, 2'd2); cycle("R9 alias status other");
    put_rd(10'h30D, 2'd1); cycle("R11 R9 low bits ignored");

    // back-to-back accepts, vector changes in the accepting cycle
    put_msg(2'd2, 5'd9, 64'h2, 64'h22); put_wr(10'h318, 2'd0, 64'h11); cycle("R4 accept with vec write");
    put_msg(2'd3, 5'd31, 64'h3, 64'h33); cycle("R4 accept cpu3");

    // R10: collision, indexed then alias
    put_msg(2'd0, 5'd5, 64'h5, 64'h55); put_wr(10'h200, 2'd3, 64'h0); cycle("R10 indexed collision");
    put_msg(2'd2, 5'd6, 64'h6, 64'h66); put_wr(10'h310, 2'd2, 64'h0); cycle("R10 alias collision");
    put_rd(10'h210, 2'd0); cycle("R10 R7 cpu2 freed, src kept");
    chk(reg_rdata, 64'h09, "R7 source unchanged on clear");

    // R7: free cpu1 and accept again; set busy by software
    put_wr(10'h208, 2'd0, 64'h0); cycle("R7 clear cpu1");
    put_msg(2'd1, 5'd12, 64'h77, 64'h88); cycle("R7 accept after clear");
    put_wr(10'h200, 2'd0, 64'h20); cycle("R7 set busy cpu0");
    put_msg(2'd0, 5'd1, 64'h1, 64'h1); cycle("R7 R3 refuse sw busy");
    put_rd(10'h000, 2'd0); cycle("R3 data0 cpu0 still zero");

    // R11: unmapped and out-of-range
    put_rd(10'h320, 2'd0); cycle("R11 unmapped");
    put_rd(10'h020, 2'd0); cycle("R11 index out of range");
    put_wr(10'h220, 2'd0, 64'h20); cycle("R11 write out of range");
    put_wr(10'h3F8, 2'd0, 64'h3F); cycle("R11 write unmapped");
    put_rd(10'h318, 2'd0); cycle("R11 vector untouched");

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(1, 0) == 1)
        put_msg(2'($urandom), 5'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
      if ($urandom_range(9, 0) < 4) begin
        logic [9:0] a;
        case ($urandom_range(7, 0))
          0: a = 10'h000 + 10'(8 * $urandom_range(4, 0));
          1: a = 10'h100 + 10'(8 * $urandom_range(4, 0));
          2, 3: a = 10'h200 + 10'(8 * $urandom_range(4, 0));
          4: a = 10'h310;
          5: a = 10'h318;
          6: a = 10'h300 + 10'(8 * $urandom_range(1, 0));
          default: a = 10'h328;
        endcase
        if ($urandom_range(1, 0) == 1) put_wr(a, 2'($urandom), {$urandom, $urandom});
        else put_rd(a, 2'($urandom));
      end
      cycle("mixed R2 R4 R7 R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule